// File: doc/BRIEF.md
# Multi-Channel Edge-Placed PWM Generator

This block produces a set of pulse-width-modulated outputs from one free-running counter and a bank of compare values. Compare value 0 defines the period. When the counter equals it, the counter returns to zero on the next clock and a one-clock cycle-start pulse marks the new period. The remaining compare values place the edges of the outputs. Each output runs in one of two placement styles:
- **Single-edge:** the output rises at the start of every period and falls on its own compare value.
- **Double-edge:** the compare value just below it raises the output and its own compare value lowers it, so both the position and the width of the pulse are free. This lets several outputs be made non-overlapping for multiphase loads.

Software writes compare values and the per-output mode bits through a plain write port. The port has no back-pressure: each write is taken in the cycle it is presented. Writes land in a shadow copy. The whole bank moves into the active copy at the end of the running period, so a period never mixes old and new settings. A per-output enable forces an output pin low without disturbing the edge state behind it.

Top module: `pwm_edge_gen`

## Requirements
- R1: The counter steps by one per clock from 0 up to active compare value 0 and then returns to 0, so a period lasts (value 0 + 1) clocks. `cycle_start_o` is high for exactly the one clock in which the counter shows 0 after such a return. This includes the return that takes place on the first clock after reset, when compare value 0 is 0.
- R2: When `wr_en` is high, `wr_addr` 0 to N_OUT writes `wr_data` into the shadow copy of that compare value. The active copy takes the whole shadow bank only on the clock edge at which the counter returns to 0. The period in progress keeps its old length and edges.
- R3: Pin `pwm_o[i]` is driven by compare value i+1 (its clear value). In double-edge mode compare value i is its set value. Edge events seen while the counter shows k appear on the pin while the counter shows k+1. In single-edge mode with clear value m below the period value P, the pin is high while the counter shows 0 through m and is low for the rest of the period.
- R4: In single-edge mode with m equal to P, the start-of-period set and the clear coincide. The clear wins and the pin stays low for the whole period. With m greater than P, the pin is high for the whole period.
- R5: In double-edge mode with set value s and clear value c, both at most P, the pin is high in steady state while the counter shows k with s < k ≤ c when s < c. When s > c, the pin is high for k > s or k ≤ c, wrapping across the period boundary.
- R6: In double-edge mode with s equal to c, the clear wins and the pin stays low.
- R7: A write to address N_OUT+1 loads the mode shadow: bit i of `wr_data` set selects double-edge for `pwm_o[i]`, clear selects single-edge. The mode bits are copied to the active copy together with the compare values.
- R8: `out_en[i]` low forces `pwm_o[i]` low at once. The edge state keeps running, so raising `out_en[i]` again mid-period shows that state immediately.
- R9: While `rst_n` is low, all pins and `cycle_start_o` are low. All shadow and active values are zero and all outputs are in single-edge mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address: 0..N_OUT compare values, N_OUT+1 mode bits |
| wr_data | input | CNT_W | Write data |
| out_en | input | N_OUT | Per-output pin enable |
| pwm_o | output | N_OUT | PWM output pins |
| cycle_start_o | output | 1 | One-clock pulse when the counter restarts at 0 |

## Verification
The bench sweeps every single-edge clear value across and beyond a small period. This covers the case where the clear value equals the period, which a design that let set beat clear would turn into a full-high output. It also covers the case where the clear value exceeds the period, which a design that wrapped the compare would shorten. Every pair of set and clear values for double-edge placement is swept, including equal pairs and pairs that wrap across the period boundary; a design with the wrong edge offset or priority would shift or invert these pulses. Mid-period writes to the period and to a clear value are checked to leave the running period alone. A design without shadowing would cut the period short or move the edge early.

// File: rtl/pwm_edge_pkg.sv
package pwm_edge_pkg;
  typedef enum logic {
    EDGE_SINGLE = 1'b0,
    EDGE_DOUBLE = 1'b1
  } edge_mode_e;

  function automatic int addr_bits(input int n_out);
    return $clog2(n_out + 2);
  endfunction
endpackage

// File: rtl/pwm_shadow_bank.sv
module pwm_shadow_bank #(
  parameter int CNT_W  = 16,
  parameter int N_OUT  = 6,
  parameter int ADDR_W = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [CNT_W-1:0]             wr_data,
  input  logic                         load,
  output logic [N_OUT:0][CNT_W-1:0]    act_mr,
  output logic [N_OUT-1:0]             act_dbl
);
  localparam int N_MATCH = N_OUT + 1;
  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(N_MATCH);

  logic [N_MATCH-1:0][CNT_W-1:0] sh_mr;
  logic [N_OUT-1:0]              sh_dbl;

  for (genvar g = 0; g < N_MATCH; g++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sh_mr[g] <= '0;
      end else if (wr_en && wr_addr == ADDR_W'(g)) begin
        sh_mr[g] <= wr_data;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        act_mr[g] <= '0;
      end else if (load) begin
        act_mr[g] <= sh_mr[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_dbl <= '0;
    end else if (wr_en && wr_addr == MODE_ADDR) begin
      sh_dbl <= wr_data[N_OUT-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_dbl <= '0;
    end else if (load) begin
      act_dbl <= sh_dbl;
    end
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic             cycle_start
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign wrap = (cnt == period);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt         <= '0;
      cycle_start <= 1'b0;
    end else begin
      cycle_start <= wrap;
      cnt         <= wrap ? '0 : cnt + ONE;
    end
  end
endmodule

// File: rtl/pwm_edge_unit.sv
module pwm_edge_unit
  import pwm_edge_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic             wrap,
  input  edge_mode_e       mode,
  input  logic [CNT_W-1:0] set_val,
  input  logic [CNT_W-1:0] clr_val,
  input  logic             en,
  output logic             edge_q,
  output logic             pin
);
  logic set_hit;
  logic clr_hit;

  always_comb begin
    if (mode == EDGE_DOUBLE) begin
      set_hit = (cnt == set_val);
    end else begin
      set_hit = wrap;
    end
    clr_hit = (cnt == clr_val);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_q <= 1'b0;
    end else if (clr_hit) begin
      edge_q <= 1'b0;
    end else if (set_hit) begin
      edge_q <= 1'b1;
    end
  end

  assign pin = edge_q & en;
endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen
  import pwm_edge_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int N_OUT  = 6,
  localparam int ADDR_W = addr_bits(N_OUT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [N_OUT-1:0]  out_en,
  output logic [N_OUT-1:0]  pwm_o,
  output logic              cycle_start_o
);
  logic [CNT_W-1:0]           cnt;
  logic                       wrap;
  logic [N_OUT:0][CNT_W-1:0]  act_mr;
  logic [N_OUT-1:0]           act_dbl;
  logic [N_OUT-1:0]           edge_q;

  pwm_shadow_bank #(
    .CNT_W (CNT_W),
    .N_OUT (N_OUT),
    .ADDR_W(ADDR_W)
  ) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .load   (wrap),
    .act_mr (act_mr),
    .act_dbl(act_dbl)
  );

  pwm_timebase #(
    .CNT_W(CNT_W)
  ) u_time (
    .clk        (clk),
    .rst_n      (rst_n),
    .period     (act_mr[0]),
    .cnt        (cnt),
    .wrap       (wrap),
    .cycle_start(cycle_start_o)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_ch
    pwm_edge_unit #(
      .CNT_W(CNT_W)
    ) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .cnt    (cnt),
      .wrap   (wrap),
      .mode   (edge_mode_e'(act_dbl[i])),
      .set_val(act_mr[i]),
      .clr_val(act_mr[i+1]),
      .en     (out_en[i]),
      .edge_q (edge_q[i]),
      .pin    (pwm_o[i])
    );
  end
endmodule

// File: rtl/pwm_edge_gen_chk.sv
module pwm_edge_gen_chk #(
  parameter int CNT_W = 16,
  parameter int N_OUT = 6
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [CNT_W-1:0]            cnt,
  input logic                        wrap,
  input logic [N_OUT:0][CNT_W-1:0]   act_mr,
  input logic [N_OUT-1:0]            act_dbl,
  input logic [N_OUT-1:0]            edge_q,
  input logic                        cycle_start_o
);
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= act_mr[0]); // R1
  AST_START_AFTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cycle_start_o); // R1
  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start_o |-> cnt == '0); // R1
  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(act_mr) && $stable(act_dbl)); // R2

  for (genvar i = 0; i < N_OUT; i++) begin : g_ch
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cnt == act_mr[i+1] |=> !edge_q[i]); // R4 R6
    AST_SINGLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !act_dbl[i] && cnt != act_mr[i+1]) |=> edge_q[i]); // R3
    AST_DOUBLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (act_dbl[i] && cnt == act_mr[i] && cnt != act_mr[i+1]) |=> edge_q[i]); // R5
  end
endmodule

bind pwm_edge_gen pwm_edge_gen_chk #(
  .CNT_W(CNT_W),
  .N_OUT(N_OUT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cnt          (cnt),
  .wrap         (wrap),
  .act_mr       (act_mr),
  .act_dbl      (act_dbl),
  .edge_q       (edge_q),
  .cycle_start_o(cycle_start_o)
);

// File: tb/pwm_edge_gen_test.sv
module pwm_edge_gen_test;
  localparam int CNT_W  = 16;
  localparam int N_OUT  = 6;
  localparam int ADDR_W = $clog2(N_OUT + 2);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [CNT_W-1:0]  wr_data = '0;
  logic [N_OUT-1:0]  out_en = '0;
  logic [N_OUT-1:0]  pwm_o;
  logic              cycle_start_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int mr [N_OUT+1];
  logic [N_OUT-1:0] mode;

  pwm_edge_gen #(.CNT_W(CNT_W), .N_OUT(N_OUT)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .out_en(out_en), .pwm_o(pwm_o),
    .cycle_start_o(cycle_start_o)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en   = 1'b1;
    wr_addr = ADDR_W'(a);
    wr_data = CNT_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic prog();
    for (int j = 0; j <= N_OUT; j++) wr(j, mr[j]);
    wr(N_OUT + 1, int'(mode));
  endtask

  task automatic wait_start();
    do @(negedge clk); while (!cycle_start_o);
  endtask

  function automatic logic exp_bit(input int i, input int k);
    int p, m, s, c;
    p = mr[0];
    if (!mode[i]) begin
      m = mr[i+1];
      if (m > p) return 1'b1;
      if (m == p) return 1'b0;
      return k <= m;
    end
    s = mr[i];
    c = mr[i+1];
    if (s == c) return 1'b0;
    if (s < c) return (k > s) && (k <= c);
    return (k > s) || (k <= c);
  endfunction

  function automatic logic [N_OUT-1:0] exp_vec(input int k);
    logic [N_OUT-1:0] v;
    for (int i = 0; i < N_OUT; i++) v[i] = exp_bit(i, k);
    return v & out_en;
  endfunction

  // samples one full settled period starting at the next cycle start
  task automatic sample_period(input string req);
    wait_start();
    for (int k = 0; k <= mr[0]; k++) begin
      if (k > 0) @(negedge clk);
      check(req, int'(pwm_o), int'(exp_vec(k)));
      check("R1 cycle_start", int'(cycle_start_o), (k == 0) ? 1 : 0);
    end
  endtask

  task automatic settle();
    wait_start();
    wait_start();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int gap;
    out_en = '1;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 pwm_o in reset", int'(pwm_o), 0);
    check("R9 cycle_start in reset", int'(cycle_start_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 first wrap after reset", int'(cycle_start_o), 1);
    check("R9 pwm_o after reset (clear equals period)", int'(pwm_o), 0);

    // R3 R4 R8: exhaustive single-edge sweep with one pin disabled per step
    mode = '0;
    mr[0] = 5;
    for (int r = 0; r < 7; r++) begin
      for (int j = 1; j <= N_OUT; j++) mr[j] = (j + r) % 7;
      out_en = ~(N_OUT'(1) << (r % N_OUT));
      prog();
      settle();
      sample_period("R3 R4 R8 single-edge sweep");
    end
    out_en = '1;

    // R5 R6 R7: all set/clear pairs, two mode patterns
    mr[0] = 4;
    for (int s = 0; s < 5; s++) begin
      for (int c = 0; c < 5; c++) begin
        for (int j = 1; j <= N_OUT; j++) mr[j] = (s + c * j) % 5;
        mode = (s % 2 == 1) ? 6'b111110 : 6'b101010;
        prog();
        settle();
        sample_period("R5 R6 R7 double-edge sweep");
      end
    end

    // R2: period written mid-period keeps the running period
    mode = '0;
    mr[0] = 5;
    for (int j = 1; j <= N_OUT; j++) mr[j] = 4;
    prog();
    settle();
    wait_start();
    wr(0, 2);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!cycle_start_o);
    check("R2 old period kept after write", gap, 5);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!cycle_start_o);
    check("R2 new period after restart", gap, 3);

    // R2: clear value written mid-period moves the edge next period
    mr[0] = 5;
    prog();
    settle();
    wait_start();
    wr(1, 1);
    for (int k = 1; k <= 5; k++) begin
      check("R2 old edge in running period", int'(pwm_o[0]), int'(k <= 4));
      @(negedge clk);
    end
    for (int k = 0; k <= 5; k++) begin
      check("R2 new edge next period", int'(pwm_o[0]), int'(k <= 1));
      if (k < 5) @(negedge clk);
    end

    // R8: state tracked while disabled
    mr[1] = 3;
    prog();
    out_en = '0;
    settle();
    wait_start();
    check("R8 disabled pin low", int'(pwm_o), 0);
    @(negedge clk);
    out_en = '1;
    #1;
    check("R8 re-enabled pin shows state", int'(pwm_o[0]), 1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule